// File: doc/BRIEF.md
# Down-Counting Event Timer with Register Interface

The block is one timer channel behind a plain 32-bit register port. A 64-bit down-counter advances once per cycle in which the `tick` strobe is high. That strobe comes from the timer clock and is treated here as synchronous to the bus clock. Software writes a 64-bit reload value as two words. A control word selects enable, one of two terminal-count behaviours (periodic reload or one-shot hold) and the interrupt mask. Software can read the live count at any time and acknowledges events by writing a one to a status word.

In periodic mode a reload value N produces one event every N+1 ticks. That gives a steady interrupt rate, or, with an all-ones reload, a wrapping time base that software reads. In one-shot mode the counter stops at zero after a single event until software turns it off and on again. A build parameter places the control word at one of two offsets, so the block fits either register-map variant.

Top module: `evt_timer`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: Reads return: reload low word at 0x00, reload high word at 0x04, count low word at 0x08, count high word at 0x0C, status at 0x18, control at 0x10 (or 0x1C when `CTRL_ALT`=1). Any other offset reads zero, and writes to it change nothing. A write to 0x1C is ignored when the control word sits at 0x10.
- R3: A control write that sets bit 0 while the timer is stopped copies the 64-bit reload value into the counter. A reload write made while the timer runs leaves the running count unchanged until the next reload.
- R4: With control bit 1 = 0 (periodic), each tick decrements the count. A tick seen while the count is zero reloads it and raises an event, so a reload of N gives one event per N+1 ticks.
- R5: With control bit 1 = 1 (one-shot), a tick at zero raises a single event. The count then stays at zero with no further events until the timer is stopped and started again, which reloads it.
- R6: Status bit 0 is set by every event, whatever the mask. Writing 1 to bit 0 at 0x18 clears it. When an event and a clear fall in the same cycle, the bit ends up set.
- R7: `irq` is high exactly when status bit 0 and control bit 2 (unmask) are both 1.
- R8: While control bit 0 is 0, ticks leave the count unchanged. Writing 0 to the control word stops the timer.
- R9: The count is a full 64-bit value: a decrement borrows from the high word into the low word, and an all-ones reload counts down across the full range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count-enable strobe, one decrement per high cycle |
| bus_wr | input | 1 | Write strobe for `bus_addr`/`bus_wdata` |
| bus_addr | input | ADDR_W (8) | Byte offset of the register |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt, status gated by the unmask bit |

## Verification
A terminal-count event and a software clear of the status bit can land in the same clock edge. The bench runs the counter down to zero and then issues a status clear with `tick` held high in that same cycle. It then reads status and expects it to be set. A second case that can coincide is a control write that starts the timer together with a tick. There the start takes priority, and the bench judges it by reading the count straight after enabling and expecting the exact reload value.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

   localparam logic [7:0] OFS_RLD_LO  = 8'h00;
   localparam logic [7:0] OFS_RLD_HI  = 8'h04;
   localparam logic [7:0] OFS_CNT_LO  = 8'h08;
   localparam logic [7:0] OFS_CNT_HI  = 8'h0C;
   localparam logic [7:0] OFS_STAT    = 8'h18;
   localparam logic [7:0] OFS_CTRL_A  = 8'h10;
   localparam logic [7:0] OFS_CTRL_B  = 8'h1C;

   // control word fields, bit 0 = enable, bit 1 = one-shot, bit 2 = unmask
   typedef struct packed {
      logic unmask;
      logic oneshot;
      logic enable;
   } ctrl_t;

endpackage

// File: rtl/evt_timer_regs.sv
module evt_timer_regs
   import evt_timer_pkg::*;
#(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned CNT_W    = 64,
   parameter bit          CTRL_ALT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [CNT_W-1:0]  cnt,
   input  logic              evt,
   output logic [CNT_W-1:0]  reload,
   output ctrl_t             ctrl,
   output logic              start,
   output logic              status
);

   localparam int unsigned CTRL_BITS = $bits(ctrl_t);

   logic [ADDR_W-1:0] ctrl_ofs;

   generate
      if (CTRL_ALT) begin : g_ctrl_b
         assign ctrl_ofs = ADDR_W'(OFS_CTRL_B);
      end else begin : g_ctrl_a
         assign ctrl_ofs = ADDR_W'(OFS_CTRL_A);
      end
   endgenerate

   logic hit_rld_lo, hit_rld_hi, hit_cnt_lo, hit_cnt_hi, hit_stat, hit_ctrl;

   always_comb begin
      hit_rld_lo = (bus_addr == ADDR_W'(OFS_RLD_LO));
      hit_rld_hi = (bus_addr == ADDR_W'(OFS_RLD_HI));
      hit_cnt_lo = (bus_addr == ADDR_W'(OFS_CNT_LO));
      hit_cnt_hi = (bus_addr == ADDR_W'(OFS_CNT_HI));
      hit_stat   = (bus_addr == ADDR_W'(OFS_STAT));
      hit_ctrl   = (bus_addr == ctrl_ofs);
   end

   ctrl_t ctrl_new;
   assign ctrl_new = ctrl_t'(bus_wdata[CTRL_BITS-1:0]);
   assign start    = bus_wr && hit_ctrl && ctrl_new.enable && !ctrl.enable;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reload <= '0;
         ctrl   <= '0;
         status <= 1'b0;
      end else begin
         if (bus_wr && hit_rld_lo) reload[DATA_W-1:0]     <= bus_wdata;
         if (bus_wr && hit_rld_hi) reload[CNT_W-1:DATA_W] <= bus_wdata;
         if (bus_wr && hit_ctrl)   ctrl                   <= ctrl_new;
         if (evt)
            status <= 1'b1;
         else if (bus_wr && hit_stat && bus_wdata[0])
            status <= 1'b0;
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (hit_rld_lo)      bus_rdata = reload[DATA_W-1:0];
      else if (hit_rld_hi) bus_rdata = reload[CNT_W-1:DATA_W];
      else if (hit_cnt_lo) bus_rdata = cnt[DATA_W-1:0];
      else if (hit_cnt_hi) bus_rdata = cnt[CNT_W-1:DATA_W];
      else if (hit_stat)   bus_rdata = {{(DATA_W-1){1'b0}}, status};
      else if (hit_ctrl)   bus_rdata = {{(DATA_W-CTRL_BITS){1'b0}}, ctrl};
   end

endmodule

// File: rtl/evt_timer_core.sv
module evt_timer_core #(
   parameter int unsigned CNT_W = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             start,
   input  logic             enable,
   input  logic             oneshot,
   input  logic [CNT_W-1:0] reload,
   output logic [CNT_W-1:0] cnt,
   output logic             evt
);

   logic done;
   logic at_zero;

   assign at_zero = (cnt == '0);
   assign evt     = enable && tick && !start && at_zero && !(oneshot && done);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt  <= '0;
         done <= 1'b0;
      end else if (start) begin
         cnt  <= reload;
         done <= 1'b0;
      end else if (enable && tick) begin
         if (!at_zero)
            cnt <= cnt - 1'b1;
         else if (!oneshot)
            cnt <= reload;
         else
            done <= 1'b1;
      end
   end

endmodule

// File: rtl/evt_timer.sv
module evt_timer
   import evt_timer_pkg::*;
#(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned CNT_W    = 64,
   parameter bit          CTRL_ALT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq
);

   generate
      if (CNT_W != 2 * DATA_W) begin : g_bad_width
         $error("evt_timer: CNT_W must be twice DATA_W");
      end
      if (ADDR_W < 5) begin : g_bad_addr
         $error("evt_timer: ADDR_W too small for the register map");
      end
   endgenerate

   ctrl_t            ctrl;
   logic [CNT_W-1:0] reload;
   logic [CNT_W-1:0] cnt;
   logic             start, evt, status;
   logic             ctrl_en, ctrl_mode, ctrl_unmask;

   assign ctrl_en     = ctrl.enable;
   assign ctrl_mode   = ctrl.oneshot;
   assign ctrl_unmask = ctrl.unmask;

   evt_timer_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .CTRL_ALT(CTRL_ALT)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt(cnt), .evt(evt),
      .reload(reload), .ctrl(ctrl), .start(start), .status(status)
   );

   evt_timer_core #(.CNT_W(CNT_W)) u_core (
      .clk(clk), .rst_n(rst_n), .tick(tick), .start(start),
      .enable(ctrl_en), .oneshot(ctrl_mode), .reload(reload),
      .cnt(cnt), .evt(evt)
   );

   assign irq = status & ctrl_unmask;

endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk #(
   parameter int unsigned CNT_W = 64
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick,
   input logic             start,
   input logic             en,
   input logic             mode,
   input logic             unmask,
   input logic             evt,
   input logic             status,
   input logic             irq,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] reload
);

   p_load_on_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> cnt == $past(reload));

   p_periodic_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !mode && tick && !start && cnt == '0) |=> cnt == $past(reload));

   p_oneshot_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (en && mode && !start && cnt == '0) |=> cnt == '0);

   p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
      evt |=> status);

   p_irq_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !unmask |-> !irq);

   p_hold_stopped_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !start) |=> $stable(cnt));

endmodule

bind evt_timer evt_timer_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .tick(tick), .start(start), .en(ctrl_en),
   .mode(ctrl_mode), .unmask(ctrl_unmask), .evt(evt), .status(status),
   .irq(irq), .cnt(cnt), .reload(reload)
);

// File: tb/evt_timer_tb_top.sv
module evt_timer_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;

   int total = 0;
   int bad   = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   evt_timer dut_i (
      .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq(irq)
   );

   typedef struct {
      bit          is_irq;
      logic [31:0] exp;
      string       req;
   } item_t;

   item_t q[$];

   // monitor: compares the queued expectation mid-cycle
   always @(negedge clk) begin
      if (q.size() > 0) begin
         item_t it;
         logic [31:0] act;
         it  = q.pop_front();
         act = it.is_irq ? {31'b0, irq} : bus_rdata;
         total++;
         if (act !== it.exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", it.req, act, it.exp);
         end
      end
   end

   task automatic wr(input logic [7:0] a, input logic [31:0] d, input bit tk = 0);
      @(posedge clk); #1;
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d; tick = tk;
      @(posedge clk); #1;
      bus_wr = 1'b0; tick = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, input logic [31:0] e, input string r);
      item_t it;
      @(posedge clk); #1;
      bus_addr = a;
      it.is_irq = 0; it.exp = e; it.req = r;
      q.push_back(it);
      @(negedge clk);
   endtask

   task automatic chk_irq(input bit e, input string r);
      item_t it;
      @(posedge clk); #1;
      it.is_irq = 1; it.exp = {31'b0, e}; it.req = r;
      q.push_back(it);
      @(negedge clk);
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #1; tick = 1'b1;
         @(posedge clk); #1; tick = 1'b0;
      end
   endtask

   initial begin
      #1_000_000;
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog: actual=hung expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1 reset state
      rd(8'h00, 0, "R1 reload lo");
      rd(8'h08, 0, "R1 count lo");
      rd(8'h10, 0, "R1 ctrl");
      rd(8'h18, 0, "R1 status");
      chk_irq(0, "R1 irq");
      // R2 map and unused offsets
      wr(8'h00, 32'd5);
      rd(8'h00, 32'd5, "R2 reload lo readback");
      wr(8'h20, 32'hABCD);
      rd(8'h20, 0, "R2 unused offset");
      wr(8'h1C, 32'h7);
      rd(8'h10, 0, "R2 alt ctrl offset ignored");
      // R3 start loads reload, running reload write ignored
      wr(8'h10, 32'h5);
      rd(8'h08, 32'd5, "R3 load on enable");
      rd(8'h10, 32'h5, "R2 ctrl readback");
      wr(8'h00, 32'd9);
      ticks(2);
      rd(8'h08, 32'd3, "R3 running count unaffected");
      // R4 periodic
      ticks(3);
      rd(8'h08, 32'd0, "R4 reached zero");
      rd(8'h18, 32'd0, "R4 no event yet");
      ticks(1);
      rd(8'h08, 32'd9, "R4 reload after N+1 ticks");
      rd(8'h18, 32'd1, "R4 event flagged");
      chk_irq(1, "R7 irq unmasked");
      // R6 clear
      wr(8'h18, 32'h1);
      rd(8'h18, 32'd0, "R6 clear");
      chk_irq(0, "R7 irq after clear");
      // R6 set wins
      ticks(9);
      rd(8'h08, 32'd0, "R6 at zero");
      wr(8'h18, 32'h1, 1);
      rd(8'h18, 32'd1, "R6 set wins over clear");
      rd(8'h08, 32'd9, "R4 reloaded in same cycle");
      // R7 masking
      wr(8'h18, 32'h1);
      wr(8'h10, 32'h1);
      ticks(10);
      rd(8'h18, 32'd1, "R6 set while masked");
      chk_irq(0, "R7 masked irq low");
      wr(8'h10, 32'h5);
      chk_irq(1, "R7 unmask raises irq");
      // R8 stop
      wr(8'h10, 32'h0);
      rd(8'h08, 32'd9, "R8 count at stop");
      ticks(3);
      rd(8'h08, 32'd9, "R8 ticks ignored when stopped");
      // R5 one-shot
      wr(8'h18, 32'h1);
      wr(8'h00, 32'd2);
      wr(8'h10, 32'h3);
      rd(8'h08, 32'd2, "R5 start one-shot");
      ticks(3);
      rd(8'h08, 32'd0, "R5 zero");
      rd(8'h18, 32'd1, "R5 event");
      wr(8'h18, 32'h1);
      ticks(4);
      rd(8'h08, 32'd0, "R5 holds zero");
      rd(8'h18, 32'd0, "R5 single event");
      wr(8'h10, 32'h0);
      wr(8'h10, 32'h3);
      rd(8'h08, 32'd2, "R5 restart reloads");
      // R9 64-bit borrow
      wr(8'h10, 32'h0);
      wr(8'h00, 32'h0);
      wr(8'h04, 32'h1);
      wr(8'h10, 32'h1);
      rd(8'h0C, 32'h1, "R9 hi loaded");
      ticks(1);
      rd(8'h0C, 32'h0, "R9 hi after borrow");
      rd(8'h08, 32'hFFFF_FFFF, "R9 lo after borrow");
      // R9 full-scale time base
      wr(8'h10, 32'h0);
      wr(8'h00, 32'hFFFF_FFFF);
      wr(8'h04, 32'hFFFF_FFFF);
      wr(8'h10, 32'h1);
      ticks(3);
      rd(8'h08, 32'hFFFF_FFFC, "R9 full-scale lo");
      rd(8'h0C, 32'hFFFF_FFFF, "R9 full-scale hi");
      rd(8'h04, 32'hFFFF_FFFF, "R2 reload hi readback");
      @(posedge clk);
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule